// File: doc/BRIEF.md
# Autonomous Row-Scrolling Display Buffer

This block holds a 256 by 64 pixel, one-bit-per-pixel image for a small monochrome panel and keeps horizontal text bands moving without help from the host. The image is split into four horizontal bands of sixteen pixel lines. The host fills a band's bytes once and then gives it a speed and a direction. A local timebase then shifts each band on its own. Rectangle fills (set, clear or invert) and a whole-screen blank run inside the block one byte per cycle. New commands are held off with a ready signal while one of these runs.

The display-facing side is a pull port. The serial panel driver presents a pixel line and a byte column and receives, one cycle later, the eight pixels that are visible there once that band's horizontal offset is applied. If the host goes quiet for a set number of timebase ticks, every band stops where it is and the last image stays on the panel. The next accepted command of any kind starts the motion again.

Top module: `oled_ticker`

## Requirements
- R1: After reset the block blanks the whole buffer by itself. cmd_ready stays low until the blank is done, scan_byte reads 0, and every byte scanned afterwards is 0.
- R2: Op 1 (band byte write) stores cmd_arg1[7:0] at band cmd_sel, line cmd_arg0[3:0] of that band, byte column cmd_arg0[8:4]. The pixel line is band*16+line. It completes in the accepting cycle and leaves neighbouring bytes untouched.
- R3: scan_byte is registered and is valid one cycle after scan_y/scan_col are presented. Bit 7 is the leftmost pixel. Screen pixel x shows buffer pixel (x + offset) mod 256 of that band's line.
- R4: Op 2 (scroll) loads band cmd_sel with speed cmd_arg0 and clears its phase accumulator. A tick occurs every TICK_DIV cycles. On each tick the speed is added to the 16-bit accumulator, and each overflow moves the offset by one pixel.
- R5: With cmd_arg1[0]=0 the offset increases, so content moves left. With cmd_arg1[0]=1 it decreases, so content moves right. Offsets wrap modulo 256.
- R6: A speed of 0 holds the band at its current offset.
- R7: Each band scrolls independently. Scrolling one band does not move another.
- R8: Op 3 (fill) covers x0=cmd_arg0[7:0], y0=cmd_arg0[15:8], x1=cmd_arg1[7:0], y1=cmd_arg1[15:8], inclusive. Mode cmd_sel selects 0 set, 1 clear, 2 invert or 3 no change. y1 is clipped to 63. An empty rectangle (x0>x1, y0>y1 or y0>63) changes nothing.
- R9: Op 4 (clear) sets every byte of the buffer to 0.
- R10: cmd_ready is low from the cycle after a fill or clear is accepted until it ends. A command held on cmd_valid meanwhile is not taken.
- R11: After HOLD_TICKS ticks with no accepted command, all offsets freeze and the image stays. Any accepted command, including unused op codes such as 0, restarts the motion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_sel | input | 2 | Band index, or fill mode for op 3 |
| cmd_arg0 | input | 16 | First argument |
| cmd_arg1 | input | 16 | Second argument |
| scan_y | input | 6 | Pixel line requested by the panel driver |
| scan_col | input | 5 | Byte column requested |
| scan_byte | output | 8 | Visible pixels at that position, one cycle later |

## Verification
The bench aims at the byte-boundary edges of fills: partial first and last bytes, a rectangle running past the bottom edge, and empty or reversed rectangles. A design with an off-by-one mask or no clipping would set stray pixels or wrap writes onto line 0. A pixel is tracked across the wrap point in both directions, so a sign error or a missing modulo shows up as the pixel in the wrong column. Other cases cover a zero-speed band drifting, a command slipping in during a fill, and a band that keeps moving after the link has gone quiet or stays frozen after the host returns.

// File: rtl/oled_pkg.sv
package oled_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ROW_BYTE = 3'd1,
        OP_SCROLL   = 3'd2,
        OP_FILL     = 3'd3,
        OP_CLEAR    = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        FM_SET  = 2'd0,
        FM_CLR  = 2'd1,
        FM_INV  = 2'd2,
        FM_KEEP = 2'd3
    } fill_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_CLEAR = 2'd2
    } busy_state_e;
endpackage

// File: rtl/oled_timebase.sv
module oled_timebase #(
    parameter int TICK_DIV   = 1526,
    parameter int HOLD_TICKS = 327680
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_fire,
    output logic step_en,
    output logic hold
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int HC_W  = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [HC_W-1:0]  quiet;
        logic             hold;
    } tb_state_t;

    tb_state_t tb_d, tb_q;
    logic      tick;

    always_comb begin
        tb_d = tb_q;
        tick = (tb_q.div == DIV_W'(TICK_DIV - 1));
        tb_d.div = tick ? '0 : tb_q.div + 1'b1;
        if (cmd_fire) begin
            tb_d.quiet = '0;
            tb_d.hold  = 1'b0;
        end else if (tick && !tb_q.hold) begin
            if (tb_q.quiet == HC_W'(HOLD_TICKS - 1)) tb_d.hold = 1'b1;
            else                                     tb_d.quiet = tb_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign step_en = tick && !tb_q.hold;
    assign hold    = tb_q.hold;

    AST_CMD_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> !hold); // R11
    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !cmd_fire) |=> hold); // R11
endmodule

// File: rtl/oled_scroll_row.sv
module oled_scroll_row #(
    parameter int X_W   = 8,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             load,
    input  logic [ACC_W-1:0] load_speed,
    input  logic             load_dir,
    output logic [X_W-1:0]   ofs
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] spd;
        logic             dir;
        logic [X_W-1:0]   ofs;
    } row_state_t;

    row_state_t rs_d, rs_q;
    logic [ACC_W:0] sum;

    always_comb begin
        rs_d = rs_q;
        sum  = {1'b0, rs_q.acc} + {1'b0, rs_q.spd};
        if (load) begin
            rs_d.spd = load_speed;
            rs_d.dir = load_dir;
            rs_d.acc = '0;
        end else if (step_en) begin
            rs_d.acc = sum[ACC_W-1:0];
            if (sum[ACC_W]) rs_d.ofs = rs_q.dir ? rs_q.ofs - 1'b1 : rs_q.ofs + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ofs = rs_q.ofs;

    AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(ofs)); // R4
    AST_ZERO_SPEED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q.spd == '0) |=> $stable(ofs)); // R6
endmodule

// File: rtl/oled_fb.sv
module oled_fb #(
    parameter int FB_W = 256,
    parameter int FB_H = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(FB_H*FB_W/8)-1:0] waddr,
    input  logic [7:0]                    wdata,
    input  logic [$clog2(FB_H*FB_W/8)-1:0] raddr,
    output logic [7:0]                    rdata,
    input  logic [$clog2(FB_H)-1:0]       scan_y,
    input  logic [$clog2(FB_W/8)-1:0]     scan_col,
    input  logic [$clog2(FB_W)-1:0]       scan_ofs,
    output logic [7:0]                    scan_byte
);
    localparam int BYTES = FB_H * FB_W / 8;
    localparam int A_W   = $clog2(BYTES);
    localparam int COL_W = $clog2(FB_W / 8);
    localparam int X_W   = $clog2(FB_W);

    logic [7:0]       mem [BYTES];
    logic [7:0]       scan_d, scan_q;
    logic [X_W-1:0]   pix;
    logic [COL_W-1:0] c_lo, c_hi;
    logic [15:0]      pair;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    always_comb begin
        pix    = {scan_col, 3'b000} + scan_ofs;
        c_lo   = pix[X_W-1:3];
        c_hi   = c_lo + 1'b1;
        pair   = {mem[A_W'({scan_y, c_lo})], mem[A_W'({scan_y, c_hi})]} << pix[2:0];
        scan_d = pair[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign scan_byte = scan_q;
endmodule

// File: rtl/oled_ticker.sv
module oled_ticker
    import oled_pkg::*;
#(
    parameter int FB_W       = 256,
    parameter int FB_H       = 64,
    parameter int ROWS       = 4,
    parameter int ACC_W      = 16,
    parameter int TICK_DIV   = 1526,
    parameter int HOLD_TICKS = 327680
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [2:0]                 cmd_op,
    input  logic [1:0]                 cmd_sel,
    input  logic [15:0]                cmd_arg0,
    input  logic [15:0]                cmd_arg1,
    input  logic [$clog2(FB_H)-1:0]    scan_y,
    input  logic [$clog2(FB_W/8)-1:0]  scan_col,
    output logic [7:0]                 scan_byte
);
    localparam int COL_W  = $clog2(FB_W / 8);
    localparam int X_W    = $clog2(FB_W);
    localparam int Y_W    = $clog2(FB_H);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int LINE_W = $clog2(FB_H / ROWS);
    localparam int A_W    = Y_W + COL_W;

    typedef struct packed {
        busy_state_e      st;
        logic [Y_W-1:0]   cy;
        logic [COL_W-1:0] cc;
        logic [Y_W-1:0]   y1;
        logic [COL_W-1:0] c0;
        logic [COL_W-1:0] c1;
        logic [X_W-1:0]   x0;
        logic [X_W-1:0]   x1;
        fill_mode_e       mode;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    logic             fire, step_en, hold;
    logic             we;
    logic [A_W-1:0]   waddr;
    logic [7:0]       wdata, rdata, mask;
    logic [X_W-1:0]   px;
    logic [7:0]       ax0, ay0, ax1, ay1;
    logic [7:0]       x1c, y1c;
    logic             empty;
    logic [X_W-1:0]   row_ofs [ROWS];
    logic [ROWS-1:0]  row_load;

    assign cmd_ready = (ctl_q.st == ST_IDLE);
    assign fire      = cmd_valid && cmd_ready;

    assign ax0 = cmd_arg0[7:0];
    assign ay0 = cmd_arg0[15:8];
    assign ax1 = cmd_arg1[7:0];
    assign ay1 = cmd_arg1[15:8];

    always_comb begin
        ctl_d = ctl_q;
        we    = 1'b0;
        waddr = {ctl_q.cy, ctl_q.cc};
        wdata = '0;
        mask  = '0;
        px    = '0;
        x1c   = (32'(ax1) > FB_W - 1) ? 8'(FB_W - 1) : ax1;
        y1c   = (32'(ay1) > FB_H - 1) ? 8'(FB_H - 1) : ay1;
        empty = (32'(ay0) > FB_H - 1) || (32'(ax0) > FB_W - 1) || (ay0 > ay1) || (ax0 > ax1);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (fire) begin
                    case (op_e'(cmd_op))
                        OP_ROW_BYTE: begin
                            we    = 1'b1;
                            waddr = {cmd_sel[ROW_W-1:0], cmd_arg0[LINE_W-1:0], cmd_arg0[LINE_W +: COL_W]};
                            wdata = cmd_arg1[7:0];
                        end
                        OP_FILL: begin
                            if (!empty) begin
                                ctl_d.st   = ST_FILL;
                                ctl_d.cy   = ay0[Y_W-1:0];
                                ctl_d.y1   = y1c[Y_W-1:0];
                                ctl_d.x0   = ax0[X_W-1:0];
                                ctl_d.x1   = x1c[X_W-1:0];
                                ctl_d.c0   = ax0[X_W-1:3];
                                ctl_d.cc   = ax0[X_W-1:3];
                                ctl_d.c1   = x1c[X_W-1:3];
                                ctl_d.mode = fill_mode_e'(cmd_sel);
                            end
                        end
                        OP_CLEAR: begin
                            ctl_d.st = ST_CLEAR;
                            ctl_d.cy = '0;
                            ctl_d.cc = '0;
                        end
                        default: ;
                    endcase
                end
            end
            ST_FILL: begin
                for (int i = 0; i < 8; i++) begin
                    px          = {ctl_q.cc, 3'(i)};
                    mask[7 - i] = (px >= ctl_q.x0) && (px <= ctl_q.x1);
                end
                we = 1'b1;
                case (ctl_q.mode)
                    FM_SET:  wdata = rdata | mask;
                    FM_CLR:  wdata = rdata & ~mask;
                    FM_INV:  wdata = rdata ^ mask;
                    default: wdata = rdata;
                endcase
                if (ctl_q.cc == ctl_q.c1) begin
                    ctl_d.cc = ctl_q.c0;
                    if (ctl_q.cy == ctl_q.y1) ctl_d.st = ST_IDLE;
                    else                      ctl_d.cy = ctl_q.cy + 1'b1;
                end else begin
                    ctl_d.cc = ctl_q.cc + 1'b1;
                end
            end
            default: begin
                we = 1'b1;
                {ctl_d.cy, ctl_d.cc} = {ctl_q.cy, ctl_q.cc} + 1'b1;
                if ({ctl_q.cy, ctl_q.cc} == '1) ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_CLEAR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    oled_timebase #(.TICK_DIV(TICK_DIV), .HOLD_TICKS(HOLD_TICKS)) u_tb (
        .clk(clk), .rst_n(rst_n), .cmd_fire(fire), .step_en(step_en), .hold(hold)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign row_load[g] = fire && (cmd_op == OP_SCROLL) && (cmd_sel[ROW_W-1:0] == ROW_W'(g));
        oled_scroll_row #(.X_W(X_W), .ACC_W(ACC_W)) u_row (
            .clk(clk), .rst_n(rst_n), .step_en(step_en), .load(row_load[g]),
            .load_speed(cmd_arg0[ACC_W-1:0]), .load_dir(cmd_arg1[0]), .ofs(row_ofs[g])
        );
    end

    oled_fb #(.FB_W(FB_W), .FB_H(FB_H)) u_fb (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr({ctl_q.cy, ctl_q.cc}), .rdata(rdata),
        .scan_y(scan_y), .scan_col(scan_col),
        .scan_ofs(row_ofs[scan_y[Y_W-1 -: ROW_W]]), .scan_byte(scan_byte)
    );

    AST_BUSY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == OP_CLEAR) |=> !cmd_ready); // R10
    AST_HOLD_NO_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !(fire && (cmd_op == OP_FILL || cmd_op == OP_CLEAR))) |=> cmd_ready); // R10
endmodule

// File: tb/tb_oled_ticker.sv
module tb_oled_ticker;
    localparam int TDIV = 4;
    localparam int HOLD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_sel = '0;
    logic [15:0] cmd_arg0 = '0;
    logic [15:0] cmd_arg1 = '0;
    logic [5:0]  scan_y = '0;
    logic [4:0]  scan_col = '0;
    logic [7:0]  scan_byte;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_acc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    oled_ticker #(.TICK_DIV(TDIV), .HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1),
        .scan_y(scan_y), .scan_col(scan_col), .scan_byte(scan_byte)
    );

    typedef struct packed {
        logic [7:0] x0; logic [7:0] y0; logic [7:0] x1; logic [7:0] y1;
        logic [1:0] mode; logic [5:0] py; logic [4:0] pc; logic [7:0] exp;
    } fill_vec_t;

    localparam fill_vec_t TBL [9] = '{
        '{8'd3,   8'd5,  8'd12,  8'd5,   2'd0, 6'd5,  5'd0,  8'h1F},
        '{8'd0,   8'd0,  8'd255, 8'd63,  2'd3, 6'd5,  5'd1,  8'hF8},
        '{8'd0,   8'd5,  8'd7,   8'd6,   2'd2, 6'd5,  5'd0,  8'hE0},
        '{8'd10,  8'd6,  8'd9,   8'd6,   2'd0, 6'd6,  5'd0,  8'hFF},
        '{8'd1,   8'd5,  8'd2,   8'd5,   2'd1, 6'd5,  5'd0,  8'h80},
        '{8'd250, 8'd60, 8'd255, 8'd200, 2'd0, 6'd63, 5'd31, 8'h3F},
        '{8'd0,   8'd64, 8'd255, 8'd70,  2'd0, 6'd0,  5'd0,  8'h00},
        '{8'd0,   8'd10, 8'd255, 8'd9,   2'd0, 6'd9,  5'd3,  8'h00},
        '{8'd248, 8'd63, 8'd255, 8'd63,  2'd2, 6'd63, 5'd31, 8'hC0}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
        end
    endtask

    task automatic chk_near(input string req, input int got, input int exp, input int tol);
        checks++;
        if (got < exp - tol || got > exp + tol) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d +/- %0d", req, got, exp, tol);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [1:0] sel,
                        input logic [15:0] a0, input logic [15:0] a1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_arg0 = a0; cmd_arg1 = a1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        last_acc  = cyc;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic rd(input int y, input int c, output int b);
        @(negedge clk);
        scan_y = 6'(y); scan_col = 5'(c);
        @(negedge clk);
        b = scan_byte;
    endtask

    task automatic find_pos(input int y, output int pos);
        int b;
        pos = -1;
        for (int c = 0; c < 32; c++) begin
            rd(y, c, b);
            if (pos < 0 && b != 0) begin
                for (int i = 0; i < 8; i++)
                    if (pos < 0 && b[7 - i]) pos = c * 8 + i;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int b, p1, p2, p3, ca, n, lowseen;
        repeat (3) @(negedge clk);
        chk("R1 scan_byte in reset", scan_byte, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready low during power-up blank", cmd_ready, 0);
        wait_idle();
        rd(33, 17, b);
        chk("R1 buffer blank after reset", b, 0);

        // R8: fill vectors, applied cumulatively to the blank buffer
        foreach (TBL[k]) begin
            send(3'd3, TBL[k].mode, {TBL[k].y0, TBL[k].x0}, {TBL[k].y1, TBL[k].x1});
            wait_idle();
            rd(TBL[k].py, TBL[k].pc, b);
            chk($sformatf("R8 fill vector %0d", k), b, TBL[k].exp);
        end
        rd(62, 31, b);
        chk("R8 clipped fill lower line", b, 8'h3F);

        // R9 / R10: clear blocks commands while running
        send(3'd4, 2'd0, 16'h0, 16'h0);
        @(negedge clk);
        chk("R10 ready low after clear", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_sel = 2'd0; cmd_arg0 = 16'h0; cmd_arg1 = 16'h00FF;
        lowseen = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cmd_ready) lowseen = 0;
        end
        cmd_valid = 1'b0;
        chk("R10 ready held low during clear", lowseen, 1);
        wait_idle();
        rd(0, 0, b);
        chk("R10 held write not taken", b, 0);
        rd(5, 0, b);
        chk("R9 clear line 5", b, 0);
        rd(63, 31, b);
        chk("R9 clear last byte", b, 0);

        // R2: band byte write
        send(3'd1, 2'd2, {7'd0, 5'd5, 4'd3}, 16'h00A5);
        rd(35, 5, b);
        chk("R2 byte written", b, 8'hA5);
        rd(35, 4, b);
        chk("R2 left neighbour untouched", b, 0);
        rd(35, 6, b);
        chk("R2 right neighbour untouched", b, 0);

        // single pixels at x=0 on line 0 of bands 0,1,2
        send(3'd1, 2'd0, 16'h0, 16'h0080);
        send(3'd1, 2'd1, 16'h0, 16'h0080);
        send(3'd1, 2'd2, 16'h0, 16'h0080);
        find_pos(32, p1);
        chk("R3 pixel position at zero offset", p1, 0);

        // R4 / R3: band 0 left at half speed
        send(3'd2, 2'd0, 16'h8000, 16'h0);
        ca = last_acc;
        repeat (200) @(negedge clk);
        send(3'd2, 2'd0, 16'h0000, 16'h0);
        n = ((last_acc - ca) / TDIV) / 2;
        find_pos(0, p1);
        chk_near("R4 left scroll offset (R3 wrap)", p1, (256 - n) % 256, 1);
        repeat (150) @(negedge clk);
        find_pos(0, p2);
        chk("R6 zero speed holds", p2, p1);
        find_pos(32, p3);
        chk("R7 other band unmoved", p3, 0);

        // R5: band 1 right
        send(3'd2, 2'd1, 16'h8000, 16'h0001);
        ca = last_acc;
        repeat (200) @(negedge clk);
        send(3'd2, 2'd1, 16'h0000, 16'h0001);
        n = ((last_acc - ca) / TDIV) / 2;
        find_pos(16, p1);
        chk_near("R5 right scroll offset", p1, n, 1);

        // R11: link-loss freeze and resume
        send(3'd1, 2'd3, 16'h0, 16'h0080);
        send(3'd2, 2'd3, 16'hFFFF, 16'h0);
        repeat (600) @(negedge clk);
        find_pos(48, p1);
        repeat (200) @(negedge clk);
        find_pos(48, p2);
        chk("R11 frozen after link loss", p2, p1);
        chk_near("R11 freeze position", p1, 256 - (HOLD - 1), 2);
        send(3'd0, 2'd0, 16'h0, 16'h0);
        repeat (100) @(negedge clk);
        send(3'd2, 2'd3, 16'h0000, 16'h0);
        find_pos(48, p3);
        chk("R11 resumes after any command", (p3 != p1) ? 1 : 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule